// File: doc/BRIEF.md
# Microcoded Control Sequencer with Opcode Translation

This block steps through a horizontal microprogram held in a parameter-loaded store. Each microword is 48 bits wide. It is read from the store and captured whole into one wide latch on every cycle. The control bits of the latched word drive the controlled datapath directly.

There is no microprogram counter and no incrementer. Every microword names its own successor. A two-bit select field in the word picks one of three sources for the next address:
- the successor field itself;
- a conditional branch, in which one condition flag replaces the lowest address bit;
- an opcode dispatch.

At a dispatch, a parameter-loaded translation table turns the irregular machine opcode into a regular class code. That code forms the high-order address bits, and the low-order bits come from the microword. Any opcode decode can be changed by reloading the table parameter, with no change to the sequencer logic.

The opcode arrives as a valid/ready stream. `opc_ready` is high exactly while the latched word is a dispatch word. An opcode transfers on a cycle where `opc_valid` and `opc_ready` are both high. While `opc_ready` is high and `opc_valid` is low, the sequencer stalls: the latch and the address hold. `opcode` and `opc_valid` are ignored whenever `opc_ready` is low. A source may raise `opc_valid` at any time and need not hold it.

Top module: `ucode_sequencer`

## Requirements
- R1: A synchronous reset clears the latch, so that `upc` = 0 and `ctrl_out` = 0 after the reset edge. In the first cycle after reset is released, the word at address 0 is fetched.
- R2: Each microword is laid out as bits [47:39] successor address, [38:37] select, [36:34] flag select and [33:0] control bits. With select 00, the next `upc` equals the successor field, and `ctrl_out` shows bits [33:0] of the word at that address.
- R3: Select code 11 is reserved and behaves exactly like 00.
- R4: With select 01 and an opcode transferred, the next `upc` is {table[opcode][5:0], successor[2:0]}.
- R5: With select 10, the next `upc` is {successor[8:1], flags[flag select]}.
- R6: `opc_ready` is 1 only while the latched word has select 01. While it is 1 and `opc_valid` is 0, `upc` and `ctrl_out` hold. Opcodes offered while `opc_ready` is 0 have no effect on the address sequence.
- R7: The translation table is a parameter of 256 six-bit entries. Differently encoded opcodes that share an entry dispatch to the same microroutine.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | 8 | Fetched machine opcode |
| opc_valid | input | 1 | Opcode stream valid |
| opc_ready | output | 1 | Sequencer is waiting on a dispatch word |
| flags | input | 8 | Condition flags for branches |
| ctrl_out | output | 34 | Control bits of the latched microword |
| upc | output | 9 | Address of the latched microword |

## Verification
On every cycle, the bound checker enforces how the next address is formed from the latched word for each select code: direct, reserved, dispatch and branch. It also checks that the latch holds during a stall and that reset clears the outputs.

Some behaviours only the bench scenarios can show. These are that the control bits come from the right store entry, that several irregular opcodes share one routine through the table, and that both the taken and the not-taken branch paths are followed. The bench runs a scoreboard model of the address sequence over a small program for this.

// File: rtl/ucode_seq_pkg.sv
package ucode_seq_pkg;

  localparam int AW_DEF    = 9;
  localparam int SELW      = 2;
  localparam int CSW_DEF   = 3;
  localparam int CW_DEF    = 34;
  localparam int OPW_DEF   = 8;
  localparam int MW_DEF    = 6;
  localparam int UW_DEF    = AW_DEF + SELW + CSW_DEF + CW_DEF;
  localparam int DEPTH_DEF = 1 << AW_DEF;
  localparam int MAPD_DEF  = 1 << OPW_DEF;

  typedef enum logic [SELW-1:0] {
    NS_NEXT     = 2'b00,
    NS_DISPATCH = 2'b01,
    NS_BRANCH   = 2'b10,
    NS_RSVD     = 2'b11
  } nsel_e;

  // Default program: word 0 dispatches, every other word returns to 0.
  function automatic logic [DEPTH_DEF*UW_DEF-1:0] default_ucode();
    logic [DEPTH_DEF*UW_DEF-1:0] img;
    logic [UW_DEF-1:0] w;
    img = '0;
    for (int i = 0; i < DEPTH_DEF; i++) begin
      w = '0;
      w[CW_DEF-1:0] = CW_DEF'(i * 37 + 1);
      if (i == 0) w[CSW_DEF+CW_DEF +: SELW] = NS_DISPATCH;
      img[i*UW_DEF +: UW_DEF] = w;
    end
    return img;
  endfunction

  // Default translation: class is the upper opcode bits.
  function automatic logic [MAPD_DEF*MW_DEF-1:0] default_map();
    logic [MAPD_DEF*MW_DEF-1:0] img;
    img = '0;
    for (int o = 0; o < MAPD_DEF; o++) img[o*MW_DEF +: MW_DEF] = MW_DEF'(o >> 2);
    return img;
  endfunction

endpackage

// File: rtl/param_lut.sv
module param_lut #(
  parameter int W     = 8,
  parameter int AW    = 4,
  parameter int DEPTH = 16,
  parameter logic [DEPTH*W-1:0] IMAGE = '0
) (
  input  logic [AW-1:0] addr,
  output logic [W-1:0]  data
);
  generate
    if (DEPTH < (1 << AW)) begin : g_partial
      always_comb begin
        if (int'(addr) < DEPTH) data = IMAGE[int'(addr)*W +: W];
        else                    data = '0;
      end
    end else begin : g_full
      always_comb data = IMAGE[int'(addr)*W +: W];
    end
  endgenerate
endmodule

// File: rtl/next_addr_sel.sv
module next_addr_sel
  import ucode_seq_pkg::*;
#(
  parameter int AW    = AW_DEF,
  parameter int CSW   = CSW_DEF,
  parameter int MW    = MW_DEF,
  parameter int NFLAG = 1 << CSW
) (
  input  logic [AW-1:0]    nxt,
  input  logic [SELW-1:0]  sel,
  input  logic [CSW-1:0]   csel,
  input  logic [NFLAG-1:0] flags,
  input  logic [MW-1:0]    map_code,
  input  logic             opc_valid,
  output logic [AW-1:0]    next_addr,
  output logic             advance,
  output logic             opc_ready
);
  localparam int LOW = AW - MW;

  nsel_e sel_e;
  assign sel_e = nsel_e'(sel);

  always_comb begin
    opc_ready = 1'b0;
    advance   = 1'b1;
    next_addr = nxt;
    unique case (sel_e)
      NS_DISPATCH: begin
        opc_ready = 1'b1;
        advance   = opc_valid;
        next_addr = {map_code, nxt[LOW-1:0]};
      end
      NS_BRANCH: next_addr = {nxt[AW-1:1], flags[csel]};
      default:   next_addr = nxt;
    endcase
  end
endmodule

// File: rtl/uword_latch.sv
module uword_latch #(
  parameter int UW = 48,
  parameter int AW = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [UW-1:0] d_word,
  input  logic [AW-1:0] d_addr,
  output logic [UW-1:0] q_word,
  output logic [AW-1:0] q_addr
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q_word <= '0;
      q_addr <= '0;
    end else if (load) begin
      q_word <= d_word;
      q_addr <= d_addr;
    end
  end
endmodule

// File: rtl/ucode_sequencer.sv
module ucode_sequencer
  import ucode_seq_pkg::*;
#(
  parameter int AW    = AW_DEF,
  parameter int CSW   = CSW_DEF,
  parameter int CW    = CW_DEF,
  parameter int OPW   = OPW_DEF,
  parameter int MW    = MW_DEF,
  parameter int NFLAG = 1 << CSW,
  parameter int UW    = AW + SELW + CSW + CW,
  parameter int DEPTH = 1 << AW,
  parameter int MAPD  = 1 << OPW,
  parameter logic [DEPTH*UW-1:0] UCODE_IMAGE = default_ucode(),
  parameter logic [MAPD*MW-1:0]  MAP_IMAGE   = default_map()
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [OPW-1:0]   opcode,
  input  logic             opc_valid,
  output logic             opc_ready,
  input  logic [NFLAG-1:0] flags,
  output logic [CW-1:0]    ctrl_out,
  output logic [AW-1:0]    upc
);
  localparam int NXT_LSB = UW - AW;
  localparam int SEL_LSB = CSW + CW;
  localparam int CS_LSB  = CW;

  logic [UW-1:0]   lat_word;
  logic [UW-1:0]   rom_word;
  logic [AW-1:0]   lat_next;
  logic [SELW-1:0] lat_sel;
  logic [CSW-1:0]  lat_csel;
  logic [MW-1:0]   map_code;
  logic [AW-1:0]   next_addr;
  logic            advance;

  assign lat_next = lat_word[NXT_LSB +: AW];
  assign lat_sel  = lat_word[SEL_LSB +: SELW];
  assign lat_csel = lat_word[CS_LSB +: CSW];
  assign ctrl_out = lat_word[CW-1:0];

  param_lut #(.W(MW), .AW(OPW), .DEPTH(MAPD), .IMAGE(MAP_IMAGE)) map_i (
    .addr(opcode),
    .data(map_code)
  );

  next_addr_sel #(.AW(AW), .CSW(CSW), .MW(MW), .NFLAG(NFLAG)) nsel_i (
    .nxt(lat_next),
    .sel(lat_sel),
    .csel(lat_csel),
    .flags(flags),
    .map_code(map_code),
    .opc_valid(opc_valid),
    .next_addr(next_addr),
    .advance(advance),
    .opc_ready(opc_ready)
  );

  param_lut #(.W(UW), .AW(AW), .DEPTH(DEPTH), .IMAGE(UCODE_IMAGE)) store_i (
    .addr(next_addr),
    .data(rom_word)
  );

  uword_latch #(.UW(UW), .AW(AW)) latch_i (
    .clk(clk),
    .rst(rst),
    .load(advance),
    .d_word(rom_word),
    .d_addr(next_addr),
    .q_word(lat_word),
    .q_addr(upc)
  );
endmodule

// File: rtl/ucode_seq_chk.sv
module ucode_seq_chk #(
  parameter int AW    = 9,
  parameter int CSW   = 3,
  parameter int CW    = 34,
  parameter int MW    = 6,
  parameter int NFLAG = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             opc_valid,
  input logic             opc_ready,
  input logic [NFLAG-1:0] flags,
  input logic [CW-1:0]    ctrl_out,
  input logic [AW-1:0]    upc,
  input logic [AW-1:0]    lat_next,
  input logic [1:0]       lat_sel,
  input logic [CSW-1:0]   lat_csel,
  input logic [MW-1:0]    map_code
);
  localparam int LOW = AW - MW;

  logic past_ok = 1'b0;
  always_ff @(posedge clk) past_ok <= 1'b1;

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
    past_ok && $past(rst) |-> (upc == '0 && ctrl_out == '0)); // R1
  AST_DIRECT_NEXT: assert property (@(posedge clk) disable iff (rst)
    past_ok && lat_sel == 2'b00 |=> upc == $past(lat_next)); // R2
  AST_RESERVED_AS_DIRECT: assert property (@(posedge clk) disable iff (rst)
    past_ok && lat_sel == 2'b11 |=> upc == $past(lat_next)); // R3
  AST_DISPATCH_ADDR: assert property (@(posedge clk) disable iff (rst)
    past_ok && opc_ready && opc_valid |=>
      upc == {$past(map_code), $past(lat_next[LOW-1:0])}); // R4
  AST_BRANCH_ADDR: assert property (@(posedge clk) disable iff (rst)
    past_ok && lat_sel == 2'b10 |=>
      upc == {$past(lat_next[AW-1:1]), $past(flags[lat_csel])}); // R5
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    past_ok && opc_ready && !opc_valid |=> $stable(upc) && $stable(ctrl_out)); // R6
endmodule

bind ucode_sequencer ucode_seq_chk #(
  .AW(AW), .CSW(CSW), .CW(CW), .MW(MW), .NFLAG(NFLAG)
) chk_i (
  .clk(clk),
  .rst(rst),
  .opc_valid(opc_valid),
  .opc_ready(opc_ready),
  .flags(flags),
  .ctrl_out(ctrl_out),
  .upc(upc),
  .lat_next(lat_next),
  .lat_sel(lat_sel),
  .lat_csel(lat_csel),
  .map_code(map_code)
);

// File: tb/ucode_sequencer_tb_top.sv
module ucode_sequencer_tb_top;

  localparam int AW = 9, CW = 34, UW = 48, DEPTH = 512, MAPD = 256, MW = 6;

  function automatic logic [CW-1:0] ctrl_of(int a);
    return {9'(a), 25'h15AC3E1 ^ 25'(a * 7)};
  endfunction

  function automatic logic [UW-1:0] mk(int nxt, int sel, int cs, int a);
    return {9'(nxt), 2'(sel), 3'(cs), ctrl_of(a)};
  endfunction

  function automatic logic [DEPTH*UW-1:0] build_prog();
    logic [DEPTH*UW-1:0] img;
    for (int a = 0; a < DEPTH; a++) img[a*UW +: UW] = mk(0, 0, 0, a);
    img[0*UW  +: UW] = mk(0, 1, 0, 0);    // fetch: dispatch, low bits 000
    img[8*UW  +: UW] = mk(9, 0, 0, 8);    // class 1 routine
    img[9*UW  +: UW] = mk(3, 3, 0, 9);    // reserved select -> go to 3
    img[16*UW +: UW] = mk(20, 2, 2, 16);  // class 2: branch on flag 2
    img[24*UW +: UW] = mk(26, 2, 5, 24);  // class 3: branch on flag 5
    img[32*UW +: UW] = mk(40, 0, 0, 32);  // class 4 -> second fetch
    img[40*UW +: UW] = mk(5, 1, 0, 40);   // dispatch, low bits 101
    return img;
  endfunction

  function automatic logic [MAPD*MW-1:0] build_map();
    logic [MAPD*MW-1:0] img;
    for (int o = 0; o < MAPD; o++) begin
      logic [MW-1:0] c;
      c = 6'd4;
      if (o == 8'h12 || o == 8'h47 || o == 8'hA3) c = 6'd1;
      else if (o == 8'h05 || o == 8'h6C)        c = 6'd2;
      else if (o >= 8'h80 && o <= 8'h8F)        c = 6'd3;
      img[o*MW +: MW] = c;
    end
    return img;
  endfunction

  localparam logic [DEPTH*UW-1:0] PROG = build_prog();
  localparam logic [MAPD*MW-1:0]  MAPT = build_map();

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [7:0]    opcode = '0;
  logic          opc_valid = 1'b0;
  logic          opc_ready;
  logic [7:0]    flags = '0;
  logic [CW-1:0] ctrl_out;
  logic [AW-1:0] upc;

  always #2.5 clk = ~clk;

  ucode_sequencer #(.UCODE_IMAGE(PROG), .MAP_IMAGE(MAPT)) dut_i (
    .clk(clk), .rst(rst), .opcode(opcode), .opc_valid(opc_valid),
    .opc_ready(opc_ready), .flags(flags), .ctrl_out(ctrl_out), .upc(upc)
  );

  typedef struct {
    logic [AW-1:0] upc;
    logic [CW-1:0] ctrl;
    logic          rdy;
    string         req;
  } exp_t;

  exp_t q[$];
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // reference model state
  logic [AW-1:0] m_addr = '0;
  bit            m_zero = 1'b1;

  task automatic step(input bit r, input bit v, input logic [7:0] opc, input logic [7:0] fl);
    logic [UW-1:0] w;
    logic [AW-1:0] nx;
    logic [1:0]    sl;
    logic [2:0]    cs;
    exp_t e;
    @(negedge clk);
    rst = r; opc_valid = v; opcode = opc; flags = fl;
    if (r) begin
      m_addr = '0; m_zero = 1'b1; e.req = "R1";
    end else begin
      w  = m_zero ? '0 : PROG[int'(m_addr)*UW +: UW];
      nx = w[47:39]; sl = w[38:37]; cs = w[36:34];
      case (sl)
        2'b01: if (v) begin
                 m_addr = {MAPT[int'(opc)*MW +: MW], nx[2:0]}; e.req = "R4 R7";
               end else e.req = "R6";
        2'b10: begin m_addr = {nx[8:1], fl[cs]}; e.req = "R5"; end
        2'b11: begin m_addr = nx; e.req = "R3"; end
        default: begin m_addr = nx; e.req = m_zero ? "R1" : "R2"; end
      endcase
      if (sl != 2'b01 && v) e.req = {e.req, " R6"};
      m_zero = 1'b0;
    end
    e.upc  = m_addr;
    e.ctrl = m_zero ? '0 : PROG[int'(m_addr)*UW + 0 +: CW];
    e.rdy  = !m_zero && (PROG[int'(m_addr)*UW + 37 +: 2] == 2'b01);
    q.push_back(e);
  endtask

  always @(posedge clk) begin
    #1;
    if (q.size() != 0) begin
      exp_t e;
      e = q.pop_front();
      n_cmp++;
      if (upc !== e.upc || ctrl_out !== e.ctrl || opc_ready !== e.rdy) begin
        n_bad++;
        $display("FAIL %s: got upc=%0d ctrl=%h rdy=%0b, expected upc=%0d ctrl=%h rdy=%0b",
                 e.req, upc, ctrl_out, opc_ready, e.upc, e.ctrl, e.rdy);
      end
    end
  end

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got hung run, expected completion");
      finish_run();
    end
  end

  initial begin
    step(1, 0, 8'h00, 8'h00);          // R1 reset
    step(1, 1, 8'h12, 8'hFF);          // R1 reset ignores opcode
    step(0, 0, 8'h00, 8'h00);          // fetch word 0
    step(0, 0, 8'h12, 8'h00);          // R6 stall
    step(0, 0, 8'h12, 8'h00);          // R6 stall
    step(0, 1, 8'h12, 8'h00);          // R4 dispatch class 1 -> 8
    step(0, 1, 8'h05, 8'h00);          // R2 -> 9, opcode ignored (R6)
    step(0, 1, 8'h80, 8'h00);          // R3 reserved -> 3
    step(0, 0, 8'h00, 8'h00);          // R2 -> 0
    step(0, 1, 8'h47, 8'h00);          // R7 same class -> 8
    step(0, 0, 8'h00, 8'h00);
    step(0, 0, 8'h00, 8'h00);
    step(0, 0, 8'h00, 8'h00);
    step(0, 1, 8'h05, 8'h00);          // class 2 -> 16
    step(0, 0, 8'h00, 8'h04);          // R5 taken -> 21
    step(0, 0, 8'h00, 8'h00);          // -> 0
    step(0, 1, 8'h6C, 8'hFB);          // class 2 -> 16
    step(0, 0, 8'h00, 8'hFB);          // R5 not taken -> 20
    step(0, 0, 8'h00, 8'h00);
    step(0, 1, 8'h83, 8'h00);          // class 3 -> 24
    step(0, 0, 8'h00, 8'h20);          // R5 taken flag 5 -> 27
    step(0, 0, 8'h00, 8'h00);
    step(0, 1, 8'h8F, 8'h00);          // class 3 -> 24
    step(0, 0, 8'h00, 8'hDF);          // R5 not taken -> 26
    step(0, 0, 8'h00, 8'h00);
    step(0, 1, 8'h00, 8'h00);          // class 4 -> 32
    step(0, 1, 8'h12, 8'h00);          // -> 40 (second dispatch word)
    step(0, 0, 8'hA3, 8'h00);          // R6 stall at 40
    step(0, 1, 8'hA3, 8'h00);          // R4 low bits 101 -> 13
    step(0, 0, 8'h00, 8'h00);          // -> 0
    step(0, 1, 8'h05, 8'h00);          // -> 16
    step(1, 0, 8'h00, 8'h00);          // R1 mid-run reset
    step(0, 0, 8'h00, 8'h00);          // fetch 0 again
    step(0, 1, 8'hFE, 8'h00);          // class 4 -> 32
    step(0, 0, 8'h00, 8'h00);
    step(0, 1, 8'h47, 8'h00);          // dispatch from 40 -> 13
    step(0, 0, 8'h00, 8'h00);
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    finish_run();
  end

endmodule